// File: doc/BRIEF.md
# FIFO Service Request Controller

This block decides when a 16-byte parallel-port data FIFO asks the host for service. It supports two service styles. With DMA enabled, it drives a DMA request line. The request stays up while the FIFO has something to move in the selected direction. It drops on a terminal count, and it is broken up so that no more than 32 back-to-back transfers happen under one request. With DMA disabled, the block raises an interrupt once the FIFO fill (toward the host) or the free space (toward the FIFO) reaches a programmable level. That level is the FIFO depth minus a programmed threshold.

The block holds the service-interrupt flag. A terminal count sets this flag, which blocks further requests. Only a host write that clears the flag re-arms the block. The FIFO storage, the peripheral handshake and host address decoding sit outside the block. Their results arrive as the occupancy count, the full and empty flags, and the host write strobe for the flag. Every output is registered and follows its inputs by one clock.

Top module: `fifo_svc_ctrl`

## Requirements
- R1: During and after synchronous reset, `dma_req`, `irq` and `svc_intr` are 0.
- R2: With `dma_en`=1, `svc_intr`=0 and `xfer_dir`=1 (FIFO to host), `dma_req` is 1 one clock after the FIFO is not empty. It is 0 one clock after the FIFO is empty, and it rises again one clock after a byte is present.
- R3: With `dma_en`=1, `svc_intr`=0 and `xfer_dir`=0 (host to FIFO), `dma_req` is 1 one clock after the FIFO is not full, and 0 one clock after it is full.
- R4: A `dma_tc` pulse drops `dma_req` and sets `svc_intr` and `irq` at the next clock. After that, `dma_req` stays 0 even with data present, until the host writes 0 to the flag. `irq` clears on that write. `dma_req` returns one clock after `svc_intr` reads 0.
- R5: While acknowledges arrive every cycle, `dma_req` stays high for exactly 32 cycles. It then falls for exactly one cycle and rises again. The beat counter restarts whenever the request is low.
- R6: Clearing `dma_en` drops `dma_req` at the next clock. Setting it back to 1 with `svc_intr`=0 and data present raises `dma_req` at the next clock.
- R7: With `dma_en`=0, `svc_intr`=0 and `xfer_dir`=1, `irq` is 1 one clock after `fifo_count` >= 16 - threshold. For threshold 12, counts 4 to 16 raise it and count 3 does not. For threshold 0, only a count of 16 raises it.
- R8: With `dma_en`=0, `svc_intr`=0 and `xfer_dir`=0, `irq` is 1 one clock after the free space (16 - `fifo_count`) >= 16 - threshold.
- R9: Threshold values of 16 and above act as 15, so one byte (or one free slot) is enough to raise the interrupt.
- R10: While `svc_intr`=1, `dma_req` is 0 and the programmed-I/O interrupt term is 0, whatever the fill.
- R11: If `dma_tc` and a host write of 0 to the flag arrive in the same cycle, the terminal count wins and `svc_intr` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | 5 | Bytes held in the FIFO, 0 to 16 |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| xfer_dir | input | 1 | 1 = FIFO to host, 0 = host to FIFO |
| dma_en | input | 1 | DMA service enable |
| svc_wr | input | 1 | Host write strobe for the service flag |
| svc_wdata | input | 1 | Value written to the service flag |
| thresh | input | 5 | Programmed threshold, 0 to 16 (larger values act as 15) |
| dma_ack | input | 1 | One pulse per completed DMA cycle |
| dma_tc | input | 1 | Terminal-count cycle seen |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Service interrupt |
| svc_intr | output | 1 | Current service flag, set by terminal count |

## Verification
The burst test holds the acknowledge high and counts the request's high cycles. A counter off by one shows 31 or 33 cycles, and a counter that is never cleared never lets the request return. The terminal-count test holds data in the FIFO after the count and checks that the request stays quiet until the host clears the flag. It also checks a terminal count against a clearing write in the same cycle, where a write with the wrong priority would wrongly re-arm the flag. The threshold tests probe the exact edge counts (3 and 4 for threshold 12, 15 and 16 for threshold 0, 0 and 1 for thresholds 15 and 16), in both directions. An inverted direction, a compare that uses > instead of >=, or a missing clamp each fails at these points.

// File: rtl/fifo_svc_pkg.sv
package fifo_svc_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int THR_W      = $clog2(FIFO_DEPTH + 1);
    localparam int BURST_MAX  = 32;
    localparam int BURST_W    = $clog2(BURST_MAX);

    typedef enum logic {
        XFER_TO_FIFO = 1'b0,
        XFER_TO_HOST = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             full;
        logic             empty;
    } fifo_stat_t;

    typedef struct packed {
        logic svc;
        logic tc_seen;
    } svc_state_t;

    // Fill needed before the programmed-I/O interrupt: depth minus the
    // threshold, with the threshold clamped to depth-1.
    function automatic logic [CNT_W-1:0] need_level(input logic [THR_W-1:0] thr);
        logic [THR_W-1:0] clamped;
        clamped = (thr > THR_W'(FIFO_DEPTH - 1)) ? THR_W'(FIFO_DEPTH - 1) : thr;
        return CNT_W'(FIFO_DEPTH) - CNT_W'(clamped);
    endfunction

    // Bytes usable in the current direction: fill toward host, space toward FIFO.
    function automatic logic [CNT_W-1:0] usable_level(input fifo_stat_t st,
                                                      input xfer_dir_e  dir);
        return (dir == XFER_TO_HOST) ? st.count : (CNT_W'(FIFO_DEPTH) - st.count);
    endfunction

endpackage

// File: rtl/svc_flag_reg.sv
module svc_flag_reg
    import fifo_svc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tc,
    input  logic       wr,
    input  logic       wdata,
    output svc_state_t state
);
    svc_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (tc) begin
            // terminal count beats any host write in the same cycle
            state_q.svc     <= 1'b1;
            state_q.tc_seen <= 1'b1;
        end else if (wr) begin
            state_q.svc <= wdata;
            if (!wdata) state_q.tc_seen <= 1'b0;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/burst_limiter.sv
module burst_limiter #(
    parameter int BURST = fifo_svc_pkg::BURST_MAX,
    localparam int BW   = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_q,
    input  logic ack,
    output logic last_beat
);
    logic [BW-1:0] beats_q;

    assign last_beat = req_q && ack && (beats_q == BW'(BURST - 1));

    always_ff @(posedge clk) begin
        if (rst || !req_q || last_beat) beats_q <= '0;
        else if (ack)                   beats_q <= beats_q + 1'b1;
    end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
    import fifo_svc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dma_en,
    input  svc_state_t state,
    input  logic       tc,
    input  fifo_stat_t stat,
    input  xfer_dir_e  dir,
    input  logic       last_beat,
    output logic       req_q
);
    logic data_ok;
    logic req_d;

    always_comb begin
        data_ok = (dir == XFER_TO_HOST) ? !stat.empty : !stat.full;
        req_d   = dma_en && !state.svc && !tc && data_ok && !last_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_d;
    end
endmodule

// File: rtl/pio_irq_gen.sv
module pio_irq_gen
    import fifo_svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_en,
    input  svc_state_t       state,
    input  fifo_stat_t       stat,
    input  xfer_dir_e        dir,
    input  logic [THR_W-1:0] thr,
    output logic             irq
);
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] need;
    logic             hit_q;

    always_comb begin
        level = usable_level(stat, dir);
        need  = need_level(thr);
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= !dma_en && !state.svc && (level >= need);
    end

    assign irq = hit_q || state.tc_seen;
endmodule

// File: rtl/fifo_svc_ctrl.sv
module fifo_svc_ctrl
    import fifo_svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic             xfer_dir,
    input  logic             dma_en,
    input  logic             svc_wr,
    input  logic             svc_wdata,
    input  logic [THR_W-1:0] thresh,
    input  logic             dma_ack,
    input  logic             dma_tc,
    output logic             dma_req,
    output logic             irq,
    output logic             svc_intr
);
    fifo_stat_t stat;
    xfer_dir_e  dir;
    svc_state_t state;
    logic       last_beat;

    assign stat = '{count: fifo_count, full: fifo_full, empty: fifo_empty};
    assign dir  = xfer_dir_e'(xfer_dir);

    svc_flag_reg u_flag (
        .clk(clk), .rst(rst), .tc(dma_tc), .wr(svc_wr), .wdata(svc_wdata),
        .state(state)
    );

    burst_limiter #(.BURST(BURST_MAX)) u_burst (
        .clk(clk), .rst(rst), .req_q(dma_req), .ack(dma_ack),
        .last_beat(last_beat)
    );

    dma_req_gen u_req (
        .clk(clk), .rst(rst), .dma_en(dma_en), .state(state), .tc(dma_tc),
        .stat(stat), .dir(dir), .last_beat(last_beat), .req_q(dma_req)
    );

    pio_irq_gen u_irq (
        .clk(clk), .rst(rst), .dma_en(dma_en), .state(state), .stat(stat),
        .dir(dir), .thr(thresh), .irq(irq)
    );

    assign svc_intr = state.svc;
endmodule

// File: rtl/fifo_svc_ctrl_chk.sv
module fifo_svc_ctrl_chk
    import fifo_svc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             xfer_dir,
    input logic             dma_en,
    input logic             svc_wr,
    input logic             svc_wdata,
    input logic             dma_ack,
    input logic             dma_tc,
    input logic             dma_req,
    input logic             irq,
    input logic             svc_intr
);
    // consecutive request-high cycles with an acknowledge
    logic [7:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || !dma_req) run_q <= '0;
        else if (dma_ack)    run_q <= run_q + 1'b1;
    end

    assert_burst_cap_R5: assert property (@(posedge clk) disable iff (rst)
        run_q <= 8'(BURST_MAX));

    assert_tc_stops_R4: assert property (@(posedge clk) disable iff (rst)
        dma_tc |=> (!dma_req && svc_intr && irq));

    assert_tc_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (dma_tc && svc_wr && !svc_wdata) |=> svc_intr);

    assert_pause_R6: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> !dma_req);

    assert_flag_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        svc_intr |=> !dma_req);

    assert_empty_stops_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_dir && fifo_empty) |=> !dma_req);

    assert_full_stops_R3: assert property (@(posedge clk) disable iff (rst)
        (!xfer_dir && fifo_full) |=> !dma_req);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dma_req && !irq && !svc_intr));
endmodule

bind fifo_svc_ctrl fifo_svc_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .xfer_dir(xfer_dir), .dma_en(dma_en),
    .svc_wr(svc_wr), .svc_wdata(svc_wdata), .dma_ack(dma_ack),
    .dma_tc(dma_tc), .dma_req(dma_req), .irq(irq), .svc_intr(svc_intr)
);

// File: tb/fifo_svc_ctrl_tb.sv
module fifo_svc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] fifo_count = '0;
    logic       fifo_full = 1'b0, fifo_empty = 1'b1;
    logic       xfer_dir = 1'b1, dma_en = 1'b0;
    logic       svc_wr = 1'b0, svc_wdata = 1'b0;
    logic [4:0] thresh = '0;
    logic       dma_ack = 1'b0, dma_tc = 1'b0;
    logic       dma_req, irq, svc_intr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fifo_svc_ctrl dut_i (
        .clk(clk), .rst(rst), .fifo_count(fifo_count), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .xfer_dir(xfer_dir), .dma_en(dma_en),
        .svc_wr(svc_wr), .svc_wdata(svc_wdata), .thresh(thresh),
        .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_req(dma_req), .irq(irq),
        .svc_intr(svc_intr)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_fill(input int n);
        fifo_count = 5'(n);
        fifo_empty = (n == 0);
        fifo_full  = (n == 16);
    endtask

    task automatic host_write(input logic v);
        svc_wr = 1'b1; svc_wdata = v;
        step();
        svc_wr = 1'b0; svc_wdata = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        check("R1 dma_req", dma_req, 0);
        check("R1 irq", irq, 0);
        check("R1 svc_intr", svc_intr, 0);
        rst = 1'b0;
        step();
        check("R1 irq after release", irq, 0);
    endtask

    task automatic t_dma_to_host();
        dma_en = 1'b1; xfer_dir = 1'b1; set_fill(0);
        step(); check("R2 empty no req", dma_req, 0);
        set_fill(3);
        step(); check("R2 data req", dma_req, 1);
        set_fill(0);
        step(); check("R2 empty drops", dma_req, 0);
        set_fill(1);
        step(); check("R2 one byte re-req", dma_req, 1);
    endtask

    task automatic t_dma_to_fifo();
        xfer_dir = 1'b0; set_fill(16);
        step(); check("R3 full no req", dma_req, 0);
        set_fill(10);
        step(); check("R3 space req", dma_req, 1);
        set_fill(16);
        step(); check("R3 full drops", dma_req, 0);
    endtask

    task automatic t_tc();
        xfer_dir = 1'b1; set_fill(5);
        step(); check("R4 req before tc", dma_req, 1);
        dma_tc = 1'b1;
        step();
        dma_tc = 1'b0;
        check("R4 req dropped", dma_req, 0);
        check("R4 flag set", svc_intr, 1);
        check("R4 irq set", irq, 1);
        step(); step();
        check("R4 req held off", dma_req, 0);
        host_write(1'b0);
        check("R4 flag cleared", svc_intr, 0);
        check("R4 irq cleared", irq, 0);
        step(); check("R4 req resumes", dma_req, 1);
    endtask

    task automatic t_burst();
        int hi = 1;
        dma_ack = 1'b1;
        for (int i = 0; i < 40; i++) begin
            step();
            if (dma_req) hi++;
            else break;
        end
        check("R5 high cycles", hi, 32);
        check("R5 low gap", dma_req, 0);
        step();
        check("R5 resumes after gap", dma_req, 1);
        dma_ack = 1'b0;
    endtask

    task automatic t_pause();
        dma_en = 1'b0;
        step(); check("R6 paused", dma_req, 0);
        dma_en = 1'b1;
        step(); check("R6 resumed", dma_req, 1);
    endtask

    task automatic t_pio_host();
        dma_en = 1'b0; xfer_dir = 1'b1; thresh = 5'd12;
        set_fill(3);  step(); check("R7 thr12 cnt3", irq, 0);
        set_fill(4);  step(); check("R7 thr12 cnt4", irq, 1);
        set_fill(16); step(); check("R7 thr12 cnt16", irq, 1);
        thresh = 5'd0;
        set_fill(15); step(); check("R7 thr0 cnt15", irq, 0);
        set_fill(16); step(); check("R7 thr0 cnt16", irq, 1);
    endtask

    task automatic t_pio_fifo();
        xfer_dir = 1'b0; thresh = 5'd12;
        set_fill(13); step(); check("R8 free3", irq, 0);
        set_fill(12); step(); check("R8 free4", irq, 1);
        set_fill(16); step(); check("R8 no space", irq, 0);
    endtask

    task automatic t_clamp();
        xfer_dir = 1'b1;
        thresh = 5'd15;
        set_fill(0); step(); check("R9 thr15 cnt0", irq, 0);
        set_fill(1); step(); check("R9 thr15 cnt1", irq, 1);
        thresh = 5'd16;
        set_fill(0); step(); check("R9 thr16 cnt0", irq, 0);
        set_fill(1); step(); check("R9 thr16 cnt1", irq, 1);
    endtask

    task automatic t_flag_blocks();
        thresh = 5'd12; set_fill(16);
        host_write(1'b1);
        step(); check("R10 pio irq masked", irq, 0);
        dma_en = 1'b1;
        step(); step(); check("R10 dma masked", dma_req, 0);
        host_write(1'b0);
        dma_en = 1'b0;
        step(); check("R10 pio back", irq, 1);
    endtask

    task automatic t_tc_priority();
        dma_tc = 1'b1; svc_wr = 1'b1; svc_wdata = 1'b0;
        step();
        dma_tc = 1'b0; svc_wr = 1'b0;
        check("R11 tc wins flag", svc_intr, 1);
        check("R11 tc wins irq", irq, 1);
        host_write(1'b0);
        check("R11 cleared later", svc_intr, 0);
    endtask

    initial begin
        t_reset();
        t_dma_to_host();
        t_dma_to_fifo();
        t_tc();
        t_burst();
        t_pause();
        t_pio_host();
        t_pio_fifo();
        t_clamp();
        t_flag_blocks();
        t_tc_priority();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule